// File: doc/BRIEF.md
# Serial Data Lock Qualifier

This block sits beside the phase detector of a clock-and-data recovery receiver and decides when the recovered stream can be trusted. It watches the reclocked serial bits, which arrive one per strobe. It also takes a phase-lock flag from the loop and two slow timing ticks: one per microsecond and one per third of the system-clock period. It raises a lock output only when three things hold together: data is toggling, the loop reports phase lock, and the loop is not running at a multiple of the true bit rate.

Harmonic false lock is found by timing. When the loop runs at twice the bit rate, every bit is sampled twice, so a stream that should contain `101` or `010` shows only `110011` or `001100`. The block restarts a watchdog on every alternating triplet. If no such triplet arrives within the watchdog window, it declares harmonic lock.

A missing strobe for a few clock cycles, such as a source switch at the same rate, does not disturb lock or mute. A longer absence drops lock within a fixed number of cycles. The mute output is always the inverse of lock.

Top module: `lql_lock_qualifier`

## Requirements
- R1: `lock_o` is high in a cycle only if `phase_lock_i` was high in the cycle before; dropping `phase_lock_i` clears `lock_o` after one clock edge.
- R2: A data transition is a strobed bit that differs from the previous strobed bit. If `US_LIMIT` pulses of `us_tick_i` arrive with no transition between them, `lock_o` falls. Fewer pulses than that leave it high.
- R3: When the last three strobed bits, oldest first, read `101` or `010`, the harmonic watchdog restarts. Once a transition and a pattern have both been seen and phase lock holds, `lock_o` rises two edges after that strobe.
- R4: If `HARM_LIMIT` pulses of `sys_tick_i` arrive with no `101`/`010` triplet between them, `lock_o` falls. This covers a double-sampled stream such as `110011001100`. Fewer pulses than that leave it high.
- R5: A gap in `rx_vld_i` of fewer than `GAP_CYC` consecutive cycles leaves `lock_o` high and `mute_o` low. A gap of `GAP_CYC` or more consecutive cycles clears `lock_o`.
- R6: After reset, `lock_o` stays low until at least one transition and at least one `101`/`010` triplet have been strobed in. A stream with transitions but no triplet, such as `0011…`, never raises lock.
- R7: `mute_o` is high exactly when `lock_o` is low, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit_i | input | 1 | Reclocked serial data bit |
| rx_vld_i | input | 1 | Strobe marking `rx_bit_i` as a new bit |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| sys_tick_i | input | 1 | One-cycle pulse once per third of the system-clock period |
| phase_lock_i | input | 1 | Phase-lock flag from the recovery loop |
| lock_o | output | 1 | Qualified lock indication |
| mute_o | output | 1 | Output mute request, inverse of lock |

## Verification
The bench builds the block with its defaults: `US_LIMIT=2`, `HARM_LIMIT=2` and `GAP_CYC=8`. With two-tick windows, the bench can test both sides of each timer. It checks that lock survives one tick and that it falls on the second. An eight-cycle gap limit lets the short-gap case, seven idle cycles checked one by one, and the dropping case sit within a few dozen cycles. Ticks are driven by hand, so a harmonic stream or a stream with no transitions is judged at an exact tick count rather than after a long wait.

// File: rtl/lql_pkg.sv
package lql_pkg;

    // Individual conditions that together qualify lock.
    typedef struct packed {
        logic data_ok;   // transitions recurring within the microsecond window
        logic harm_ok;   // alternating triplet recurring within the harmonic window
        logic phase_ok;  // loop reports phase lock
        logic link_ok;   // strobe gap still shorter than the hold limit
    } lql_cond_t;

    // True when three bits (oldest in bit 2) alternate.
    function automatic logic is_alt3(input logic [2:0] w);
        return (w == 3'b101) || (w == 3'b010);
    endfunction

    function automatic logic cond_met(input lql_cond_t c);
        return c.data_ok & c.harm_ok & c.phase_ok & c.link_ok;
    endfunction

endpackage

// File: rtl/lql_bit_history.sv
module lql_bit_history
    import lql_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic vld_i,
    output logic edge_o,
    output logic alt_o
);

    logic [1:0] hist_q;  // hist_q[1] older, hist_q[0] newest
    logic [1:0] fill_q;  // number of valid bits held, saturates at 2

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (vld_i) begin
            hist_q <= {hist_q[0], bit_i};
            if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
        end
    end

    assign edge_o = vld_i && (fill_q != 2'd0) && (bit_i != hist_q[0]);
    assign alt_o  = vld_i && (fill_q == 2'd2) && is_alt3({hist_q, bit_i});

endmodule

// File: rtl/lql_watchdog.sv
module lql_watchdog #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic tick_i,
    output logic ok_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Starts expired so the qualifying event must be seen after reset.
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= TOP;
        else if (restart_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q != TOP))
            cnt_q <= cnt_q + 1'b1;
    end

    assign ok_o = (cnt_q != TOP);

endmodule

// File: rtl/lql_lock_qualifier.sv
module lql_lock_qualifier
    import lql_pkg::*;
#(
    parameter int US_LIMIT   = 2,
    parameter int HARM_LIMIT = 2,
    parameter int GAP_CYC    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    input  logic us_tick_i,
    input  logic sys_tick_i,
    input  logic phase_lock_i,
    output logic lock_o,
    output logic mute_o
);

    logic      bit_edge;
    logic      bit_alt;
    lql_cond_t cond;
    logic      lock_q;

    lql_bit_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (rx_bit_i),
        .vld_i  (rx_vld_i),
        .edge_o (bit_edge),
        .alt_o  (bit_alt)
    );

    // Transition presence, timed in microsecond ticks.
    lql_watchdog #(.LIMIT(US_LIMIT)) u_data_wd (
        .clk       (clk),
        .rst       (rst),
        .restart_i (bit_edge),
        .tick_i    (us_tick_i),
        .ok_o      (cond.data_ok)
    );

    // Harmonic guard, timed in system-period thirds.
    lql_watchdog #(.LIMIT(HARM_LIMIT)) u_harm_wd (
        .clk       (clk),
        .rst       (rst),
        .restart_i (bit_alt),
        .tick_i    (sys_tick_i),
        .ok_o      (cond.harm_ok)
    );

    // Strobe gap, timed in block clock cycles.
    lql_watchdog #(.LIMIT(GAP_CYC)) u_gap_wd (
        .clk       (clk),
        .rst       (rst),
        .restart_i (rx_vld_i),
        .tick_i    (1'b1),
        .ok_o      (cond.link_ok)
    );

    assign cond.phase_ok = phase_lock_i;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= cond_met(cond);
    end

    assign lock_o = lock_q;
    assign mute_o = ~lock_q;

endmodule

// File: rtl/lql_lock_qualifier_chk.sv
module lql_lock_qualifier_chk #(
    parameter int US_LIMIT   = 2,
    parameter int HARM_LIMIT = 2,
    parameter int GAP_CYC    = 8
) (
    input logic clk,
    input logic rst,
    input logic rx_bit_i,
    input logic rx_vld_i,
    input logic us_tick_i,
    input logic sys_tick_i,
    input logic phase_lock_i,
    input logic lock_o
);

    int   idle_n;
    int   us_n;
    int   harm_n;
    int   seen_n;
    logic last_bit;
    logic prev_bit;
    logic pat_seen;
    logic cur_alt;

    assign cur_alt = rx_vld_i && (seen_n >= 2) &&
                     (rx_bit_i != last_bit) && (last_bit != prev_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_n   <= 0;
            us_n     <= US_LIMIT;
            harm_n   <= HARM_LIMIT;
            seen_n   <= 0;
            last_bit <= 1'b0;
            prev_bit <= 1'b0;
            pat_seen <= 1'b0;
        end else begin
            if (rx_vld_i) idle_n <= 0;
            else if (idle_n <= GAP_CYC) idle_n <= idle_n + 1;

            if (rx_vld_i && (seen_n >= 1) && (rx_bit_i != last_bit)) us_n <= 0;
            else if (us_tick_i && (us_n < US_LIMIT)) us_n <= us_n + 1;

            if (cur_alt) harm_n <= 0;
            else if (sys_tick_i && (harm_n < HARM_LIMIT)) harm_n <= harm_n + 1;

            if (cur_alt) pat_seen <= 1'b1;

            if (rx_vld_i) begin
                prev_bit <= last_bit;
                last_bit <= rx_bit_i;
                if (seen_n < 2) seen_n <= seen_n + 1;
            end
        end
    end

    AST_LOCK_NEEDS_PHASE: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> $past(phase_lock_i));  // R1

    AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (us_n >= US_LIMIT) |=> !lock_o);  // R2

    AST_HARM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (harm_n >= HARM_LIMIT) |=> !lock_o);  // R4

    AST_GAP_DROP: assert property (@(posedge clk) disable iff (rst)
        (idle_n > GAP_CYC) |-> !lock_o);  // R5

    AST_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> pat_seen);  // R6

endmodule

bind lql_lock_qualifier lql_lock_qualifier_chk #(
    .US_LIMIT   (US_LIMIT),
    .HARM_LIMIT (HARM_LIMIT),
    .GAP_CYC    (GAP_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_bit_i     (rx_bit_i),
    .rx_vld_i     (rx_vld_i),
    .us_tick_i    (us_tick_i),
    .sys_tick_i   (sys_tick_i),
    .phase_lock_i (phase_lock_i),
    .lock_o       (lock_o)
);

// File: tb/lql_lock_qualifier_bench.sv
module lql_lock_qualifier_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit_i = 1'b0;
    logic rx_vld_i = 1'b0;
    logic us_tick_i = 1'b0;
    logic sys_tick_i = 1'b0;
    logic phase_lock_i = 1'b0;
    logic lock_o;
    logic mute_o;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    logic tog = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lql_lock_qualifier u_lql_lock_qualifier (
        .clk          (clk),
        .rst          (rst),
        .rx_bit_i     (rx_bit_i),
        .rx_vld_i     (rx_vld_i),
        .us_tick_i    (us_tick_i),
        .sys_tick_i   (sys_tick_i),
        .phase_lock_i (phase_lock_i),
        .lock_o       (lock_o),
        .mute_o       (mute_o)
    );

    task automatic drive(input logic b, input logic v, input logic ut, input logic st);
        @(negedge clk);
        rx_bit_i   = b;
        rx_vld_i   = v;
        us_tick_i  = ut;
        sys_tick_i = st;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_lock(input string req, input logic exp);
        check({req, " lock"}, lock_o, exp);
        check({req, " mute (R7)"}, mute_o, ~exp);
    endtask

    task automatic feed_alt(input int n);
        for (int i = 0; i < n; i++) begin
            tog = ~tog;
            drive(tog, 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        phase_lock_i = 1'b1;
        repeat (4) drive(1'b0, 1'b1, 1'b0, 1'b0);
        check_lock("R6 reset", 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_startup;
        // transitions but no alternating triplet: lock must stay low (R6)
        for (int i = 0; i < 16; i++) drive(i[1], 1'b1, 1'b0, 1'b0);
        check_lock("R6 no pattern yet", 1'b0);
        feed_alt(6);
        check_lock("R3 acquire", 1'b1);
    endtask

    task automatic t_phase;
        phase_lock_i = 1'b0;
        feed_alt(2);
        check_lock("R1 phase dropped", 1'b0);
        phase_lock_i = 1'b1;
        feed_alt(3);
        check_lock("R1 phase restored", 1'b1);
    endtask

    task automatic t_no_transition;
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0);  // first microsecond tick
        repeat (3) drive(1'b1, 1'b1, 1'b0, 1'b0);
        check_lock("R2 one tick tolerated", 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b0);  // second tick, window expired
        repeat (2) drive(1'b1, 1'b1, 1'b0, 1'b0);
        check_lock("R2 no transition", 1'b0);
        tog = 1'b1;
        feed_alt(4);
        check_lock("R2 recovered", 1'b1);
    endtask

    task automatic t_harmonic;
        // double-sampled stream 110011001100...
        for (int i = 0; i < 6; i++) drive(~i[1], 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);  // first system tick
        for (int i = 0; i < 4; i++) drive(i[1], 1'b1, 1'b0, 1'b0);
        check_lock("R4 one tick tolerated", 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1);  // second system tick
        for (int i = 0; i < 3; i++) drive(i[1], 1'b1, 1'b0, 1'b0);
        check_lock("R4 harmonic lock", 1'b0);
        feed_alt(4);
        check_lock("R3 pattern restores lock", 1'b1);
    endtask

    task automatic t_gaps;
        for (int i = 0; i < GAP - 1; i++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0);
            check_lock("R5 short gap", 1'b1);
        end
        feed_alt(1);
        check_lock("R5 short gap end", 1'b1);
        feed_alt(2);
        check_lock("R5 after short gap", 1'b1);
        repeat (GAP + 4) drive(1'b0, 1'b0, 1'b0, 1'b0);
        check_lock("R5 long gap", 1'b0);
        feed_alt(4);
        check_lock("R5 data back", 1'b1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_phase();
        t_no_transition();
        t_harmonic();
        t_gaps();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule